// File: doc/BRIEF.md
# Bidirectional Cascaded Sampling Pulse Generator

This block generates the column sampling strobes for a 300-column line driver. A single start token walks a 100-stage one-hot shift register; every stage owns a group of three adjacent columns. Each time the token is serviced, one column or a whole three-column group receives a one-cycle strobe. The three clock phases of the panel timing arrive as single-cycle enables on one system clock. A start is taken only on a phase-1 enable.

The direction input swaps the roles of the two end pins. In one direction, the low-column end takes the start and the high-column end drives the cascade toward the next driver in the chain. In the other direction, the roles are reversed and the column order runs backwards. The mode input selects between two schemes. In simultaneous mode, phase 1 alone strobes all three columns of a group. In sequential mode, the three phases strobe the three columns of a group one at a time, in a fixed order.

The cascade output is high while the token waits in the last stage for that group's first firing phase. A downstream chip fed from this pin therefore loads on that same phase-1 edge and strobes its first group on the next one.

Top module: `samp_strobe_gen`

## Requirements
- R1: The token visits the 100 stages in order, one stage per group service. Across one line, every column is strobed exactly once: strobe bit k is column k+1.
- R2: When `dir_up`=1, `start_lo_in` is the start, `casc_hi_out` is the cascade, and columns run from bit 0 up to bit 299. When `dir_up`=0, `start_hi_in` is the start, `casc_lo_out` is the cascade, and columns run from bit 299 down to bit 0. The unselected start pin is ignored, and the unselected cascade pin stays low.
- R3: When `mode_sim`=1, each phase-1 enable with a token present strobes all three bits of the current group, and `ph2_en`/`ph3_en` have no effect. The first group fires on the phase-1 enable after the one that loaded the start.
- R4: A strobe bit is high for exactly one cycle. It is high only in the cycle after a clock edge at which a phase enable was high.
- R5: When `mode_sim`=0, step 1 of a group waits for `ph1_en`, step 2 for `ph2_en`, and step 3 for `ph3_en`; any other enable is ignored. Each step strobes one bit. With `dir_up`=1, the steps give group offsets 0, 1, 2 (bits 3g, 3g+1, 3g+2). With `dir_up`=0, they give bits 299-3g, 298-3g, 297-3g. The token moves to the next group only after step 3.
- R6: A start level held high over many phase-1 enables loads only one token. The start must be seen low before it can load again.
- R7: A start is ignored while a token is in the chain.
- R8: The selected cascade pin is high from the edge at which the token enters the last stage until the edge at which that stage's first step fires.
- R9: A synchronous reset (`rst`=1) clears the chain, all strobes and both cascade pins. After reset, the start is armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| dir_up | input | 1 | 1: columns ascend, 0: columns descend |
| mode_sim | input | 1 | 1: one phase strobes a whole group, 0: three staggered phases |
| ph1_en | input | 1 | Phase-1 rising-edge enable |
| ph2_en | input | 1 | Phase-2 rising-edge enable |
| ph3_en | input | 1 | Phase-3 rising-edge enable |
| start_lo_in | input | 1 | Start at the low-column end (used when dir_up=1) |
| start_hi_in | input | 1 | Start at the high-column end (used when dir_up=0) |
| casc_lo_out | output | 1 | Cascade at the low-column end (driven when dir_up=0) |
| casc_hi_out | output | 1 | Cascade at the high-column end (driven when dir_up=1) |
| strobe | output | 300 | One-cycle column sampling strobes |

## Verification
The bench sweeps every group in all four combinations of direction and mode. It checks the exact strobe word after each phase enable. A decoder with a swapped left-shift phase map would strobe the wrong end of a group. A chain that advanced after every phase would skip columns.

In sequential mode, the bench injects enables that arrive out of order or together. A design that fired on any phase would give extra strobes.

The bench also does the following:
- It holds the start high across whole lines and re-raises it mid-line. A level-triggered or non-locked capture would then restart the token or emit a second line.
- It checks the cascade window on both pins around the last stage. An off-by-one would show the cascade one group early, or would leave it high after the line ends.

// File: rtl/sps_pkg.sv
package sps_pkg;

    localparam int unsigned GRP_COLS = 3;

    typedef enum logic [1:0] {
        STEP_A = 2'd0,
        STEP_B = 2'd1,
        STEP_C = 2'd2
    } step_e;

    typedef struct packed {
        logic p1;
        logic p2;
        logic p3;
    } phase_t;

    // Which phase enable a sequential step waits for.
    function automatic logic phase_hit(input phase_t ph, input step_e s);
        case (s)
            STEP_A:  return ph.p1;
            STEP_B:  return ph.p2;
            STEP_C:  return ph.p3;
            default: return 1'b0;
        endcase
    endfunction

    function automatic step_e step_next(input step_e s);
        case (s)
            STEP_A:  return STEP_B;
            STEP_B:  return STEP_C;
            default: return STEP_A;
        endcase
    endfunction

endpackage

// File: rtl/sps_start_capture.sv
module sps_start_capture (
    input  logic clk,
    input  logic rst,
    input  logic dir_up,
    input  logic start_lo_in,
    input  logic start_hi_in,
    input  logic ph1,
    input  logic busy,
    output logic load
);
    logic armed_q;
    logic start_sel;

    assign start_sel = dir_up ? start_lo_in : start_hi_in;
    assign load      = ph1 & start_sel & armed_q & ~busy;

    // Arm only once the start has been seen low; disarm on load.
    always_ff @(posedge clk) begin
        if (rst)
            armed_q <= 1'b1;
        else if (load)
            armed_q <= 1'b0;
        else if (!start_sel)
            armed_q <= 1'b1;
    end

    // R6: a held start cannot load twice back to back
    p_one_load_r6: assert property (@(posedge clk) disable iff (rst)
        load |=> !load);

endmodule

// File: rtl/sps_token_chain.sv
module sps_token_chain
    import sps_pkg::*;
#(
    parameter int unsigned NUM_STAGES = 100
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  load,
    input  logic                  mode_sim,
    input  phase_t                ph,
    output logic [NUM_STAGES-1:0] tok,
    output step_e                 step,
    output logic                  fire,
    output logic                  busy
);
    logic adv;

    assign busy = |tok;
    assign fire = busy & (mode_sim ? ph.p1 : phase_hit(ph, step));
    assign adv  = fire & (mode_sim | (step == STEP_C));

    for (genvar i = 0; i < NUM_STAGES; i++) begin : g_stage
        logic from_prev;
        logic q;
        if (i == 0) begin : g_head
            assign from_prev = 1'b0;
        end else begin : g_body
            assign from_prev = tok[i-1];
        end
        always_ff @(posedge clk) begin
            if (rst)
                q <= 1'b0;
            else if (load)
                q <= (i == 0);
            else if (adv)
                q <= from_prev;
        end
        assign tok[i] = q;
    end

    always_ff @(posedge clk) begin
        if (rst || load || adv)
            step <= STEP_A;
        else if (fire)
            step <= step_next(step);
    end

    // R1: never more than one token in the chain
    p_tok_onehot_r1: assert property (@(posedge clk) disable iff (rst)
        $onehot0(tok));

    // R1: an advance from a non-final stage keeps the token alive
    p_adv_keeps_r1: assert property (@(posedge clk) disable iff (rst)
        (adv && !tok[NUM_STAGES-1]) |=> busy);

    // R5: an empty chain sits on the first step
    p_idle_step_r5: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (step == STEP_A));

endmodule

// File: rtl/sps_col_decode.sv
module sps_col_decode
    import sps_pkg::*;
#(
    parameter int unsigned NUM_STAGES = 100
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             dir_up,
    input  logic                             mode_sim,
    input  logic                             fire,
    input  step_e                            step,
    input  logic [NUM_STAGES-1:0]            tok,
    output logic [NUM_STAGES*GRP_COLS-1:0]   strobe
);
    localparam int unsigned NCOL = NUM_STAGES * GRP_COLS;

    for (genvar c = 0; c < NCOL; c++) begin : g_col
        localparam int unsigned UP_STG = c / GRP_COLS;
        localparam int unsigned UP_OFS = c % GRP_COLS;
        localparam int unsigned DN_LI  = NCOL - 1 - c;
        localparam int unsigned DN_STG = DN_LI / GRP_COLS;
        localparam int unsigned DN_OFS = DN_LI % GRP_COLS;

        logic hit_up, hit_dn, q;

        assign hit_up = tok[UP_STG] & (mode_sim | (step == step_e'(2'(UP_OFS))));
        assign hit_dn = tok[DN_STG] & (mode_sim | (step == step_e'(2'(DN_OFS))));

        always_ff @(posedge clk) begin
            if (rst)
                q <= 1'b0;
            else
                q <= fire & (dir_up ? hit_up : hit_dn);
        end
        assign strobe[c] = q;
    end

    // R4: a strobe only follows an edge at which some phase fired
    p_strobe_fire_r4: assert property (@(posedge clk) disable iff (rst)
        (|strobe) |-> $past(fire));

endmodule

// File: rtl/samp_strobe_gen.sv
module samp_strobe_gen
    import sps_pkg::*;
#(
    parameter int unsigned NUM_STAGES = 100
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           dir_up,
    input  logic                           mode_sim,
    input  logic                           ph1_en,
    input  logic                           ph2_en,
    input  logic                           ph3_en,
    input  logic                           start_lo_in,
    input  logic                           start_hi_in,
    output logic                           casc_lo_out,
    output logic                           casc_hi_out,
    output logic [NUM_STAGES*GRP_COLS-1:0] strobe
);
    phase_t                ph;
    logic                  load, fire, busy, casc;
    logic [NUM_STAGES-1:0] tok;
    step_e                 step;

    assign ph = {ph1_en, ph2_en, ph3_en};

    sps_start_capture u_cap (
        .clk         (clk),
        .rst         (rst),
        .dir_up      (dir_up),
        .start_lo_in (start_lo_in),
        .start_hi_in (start_hi_in),
        .ph1         (ph1_en),
        .busy        (busy),
        .load        (load)
    );

    sps_token_chain #(.NUM_STAGES(NUM_STAGES)) u_chain (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .mode_sim (mode_sim),
        .ph       (ph),
        .tok      (tok),
        .step     (step),
        .fire     (fire),
        .busy     (busy)
    );

    sps_col_decode #(.NUM_STAGES(NUM_STAGES)) u_dec (
        .clk      (clk),
        .rst      (rst),
        .dir_up   (dir_up),
        .mode_sim (mode_sim),
        .fire     (fire),
        .step     (step),
        .tok      (tok),
        .strobe   (strobe)
    );

    // Cascade is high while the last group waits for its first step.
    assign casc        = tok[NUM_STAGES-1] & (step == STEP_A);
    assign casc_hi_out = dir_up & casc;
    assign casc_lo_out = ~dir_up & casc;

    // R3: simultaneous mode strobes a whole group at once
    p_sim_group_r3: assert property (@(posedge clk) disable iff (rst)
        ((|strobe) && $past(mode_sim)) |-> ($countones(strobe) == GRP_COLS));

    // R5: sequential mode strobes one column at a time
    p_seq_single_r5: assert property (@(posedge clk) disable iff (rst)
        ((|strobe) && !$past(mode_sim)) |-> ($countones(strobe) == 1));

    // R9: reset leaves every output low on the next cycle
    p_reset_clear_r9: assert property (@(posedge clk)
        rst |=> ((strobe == '0) && !casc_lo_out && !casc_hi_out));

endmodule

// File: tb/sim_samp_strobe_gen.sv
`timescale 1ns/100ps
module sim_samp_strobe_gen;
    localparam int NS = 100;
    localparam int NC = NS * 3;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst, dir_up, mode_sim, ph1_en, ph2_en, ph3_en, start_lo_in, start_hi_in;
    logic casc_lo_out, casc_hi_out;
    logic [NC-1:0] strobe;

    int  total = 0;
    int  bad   = 0;
    bit  done  = 1'b0;

    samp_strobe_gen #(.NUM_STAGES(NS)) u0 (
        .clk(clk), .rst(rst), .dir_up(dir_up), .mode_sim(mode_sim),
        .ph1_en(ph1_en), .ph2_en(ph2_en), .ph3_en(ph3_en),
        .start_lo_in(start_lo_in), .start_hi_in(start_hi_in),
        .casc_lo_out(casc_lo_out), .casc_hi_out(casc_hi_out), .strobe(strobe)
    );

    function automatic logic [NC-1:0] cols(input int first, input int n);
        logic [NC-1:0] m = '0;
        for (int k = 0; k < n; k++) m[first+k] = 1'b1;
        return m;
    endfunction

    task automatic chk_v(input string tag, input logic [NC-1:0] act, input logic [NC-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s strobe act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic chk_b(input string tag, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%b exp=%b", tag, act, exp);
        end
    endtask

    // Drive enables, take one edge, sample shortly after it.
    task automatic cyc(input bit a, input bit b, input bit c);
        ph1_en = a; ph2_en = b; ph3_en = c;
        @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL watchdog act=running exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; dir_up = 1'b1; mode_sim = 1'b1;
        ph1_en = 0; ph2_en = 0; ph3_en = 0; start_lo_in = 0; start_hi_in = 0;
        cyc(0, 0, 0);
        cyc(1, 1, 1);
        chk_v("R9 reset strobes", strobe, '0);
        chk_b("R9 reset casc_hi", casc_hi_out, 1'b0);
        chk_b("R9 reset casc_lo", casc_lo_out, 1'b0);
        rst = 1'b0;

        // Simultaneous, ascending; unused start pin held high throughout
        dir_up = 1; mode_sim = 1; start_lo_in = 1; start_hi_in = 1;
        cyc(1, 0, 0);
        chk_v("R3 load edge gives no strobe", strobe, '0);
        for (int g = 0; g < NS; g++) begin
            if (g == 40) start_lo_in = 0;
            if (g == 41) start_lo_in = 1;   // R7: re-armed start while busy
            if (g == 60) start_lo_in = 0;
            cyc(0, 1, 1);
            chk_v("R3/R4 ph2/ph3 idle in sim mode", strobe, '0);
            if (g == NS-1) begin
                chk_b("R8 casc_hi in last stage", casc_hi_out, 1'b1);
                chk_b("R2 casc_lo unused", casc_lo_out, 1'b0);
            end
            cyc(1, 0, 0);
            chk_v("R1/R7 sim up group", strobe, cols(3*g, 3));
        end
        chk_b("R8 casc_hi drops after line", casc_hi_out, 1'b0);
        for (int k = 0; k < 3; k++) begin
            cyc(1, 0, 0);
            chk_v("R2 unselected start ignored", strobe, '0);
        end

        // Simultaneous, descending; start held high for the whole line
        dir_up = 0;
        cyc(1, 0, 0);
        chk_v("R2 load from hi pin", strobe, '0);
        for (int g = 0; g < NS; g++) begin
            if (g == NS-1) begin
                cyc(0, 0, 0);
                chk_b("R8 casc_lo in last stage", casc_lo_out, 1'b1);
                chk_b("R2 casc_hi unused", casc_hi_out, 1'b0);
            end
            cyc(1, 0, 0);
            chk_v("R2 sim down group", strobe, cols(NC-3-3*g, 3));
        end
        chk_b("R8 casc_lo drops after line", casc_lo_out, 1'b0);
        for (int k = 0; k < 3; k++) begin
            cyc(1, 0, 0);
            chk_v("R6 held start loads once", strobe, '0);
        end
        start_hi_in = 0;
        cyc(0, 0, 0);

        // Sequential, ascending, with stray enables
        dir_up = 1; mode_sim = 0; start_lo_in = 1;
        cyc(1, 0, 0);
        chk_v("R5 seq load", strobe, '0);
        start_lo_in = 0;
        for (int g = 0; g < NS; g++) begin
            cyc(0, 0, 1);
            chk_v("R5 ph3 before ph1 ignored", strobe, '0);
            if (g == NS-1) chk_b("R8 seq casc_hi", casc_hi_out, 1'b1);
            if (g % 2 == 0) cyc(1, 1, 1); else cyc(1, 0, 0);
            chk_v("R5 seq up step1", strobe, cols(3*g, 1));
            cyc(1, 0, 1);
            chk_v("R5 ph1/ph3 at step2 ignored", strobe, '0);
            cyc(0, 1, 0);
            chk_v("R5 seq up step2", strobe, cols(3*g+1, 1));
            cyc(0, 1, 0);
            chk_v("R5 ph2 at step3 ignored", strobe, '0);
            cyc(0, 0, 1);
            chk_v("R5 seq up step3", strobe, cols(3*g+2, 1));
            if (g == NS-1) chk_b("R8 seq casc_hi after line", casc_hi_out, 1'b0);
        end

        // Sequential, descending
        dir_up = 0; start_hi_in = 1;
        cyc(1, 0, 0);
        chk_v("R5 seq down load", strobe, '0);
        start_hi_in = 0;
        for (int g = 0; g < NS; g++) begin
            cyc(1, 0, 0);
            chk_v("R5 seq down ph1 high col", strobe, cols(NC-1-3*g, 1));
            if (g == NS-1) chk_b("R8 seq casc_lo falls", casc_lo_out, 1'b0);
            cyc(0, 1, 0);
            chk_v("R5 seq down ph2 mid col", strobe, cols(NC-2-3*g, 1));
            cyc(0, 0, 1);
            chk_v("R5 seq down ph3 low col", strobe, cols(NC-3-3*g, 1));
            if (g == NS-2) chk_b("R8 seq casc_lo rises", casc_lo_out, 1'b1);
        end

        // Reset in mid-line
        dir_up = 1; mode_sim = 1; start_lo_in = 1;
        cyc(1, 0, 0);
        cyc(1, 0, 0);
        chk_v("R1 first group", strobe, cols(0, 3));
        cyc(1, 0, 0);
        chk_v("R1 second group", strobe, cols(3, 3));
        rst = 1; start_lo_in = 0;
        cyc(1, 0, 0);
        chk_v("R9 mid-line reset strobes", strobe, '0);
        chk_b("R9 mid-line reset casc", casc_hi_out | casc_lo_out, 1'b0);
        rst = 0;
        cyc(1, 0, 0);
        chk_v("R9 token cleared", strobe, '0);
        cyc(1, 0, 0);
        chk_v("R9 still idle", strobe, '0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule